// File: doc/BRIEF.md
# Ethernet PHY Status LED Controller

This block drives the three status lamps of a 10/100 Ethernet PHY. One lamp shows the link, one shows the speed and one shows activity. Its inputs are the line state from the rest of the PHY: link up, 100 Mb/s speed, transmit busy, receive busy, collision and full duplex. A static two-bit mode select chooses what the link and activity lamps mean. A static invert input sets whether a lamp is lit by a high or by a low output level.

Lamp timing comes from a prescaled tick, which is one pulse every `TICK_DIV` system clocks. Short traffic and collision events are stretched to a pulse of `STRETCH_TICKS` ticks that a person can see. A new event during a pulse starts the pulse again. In the two blinking modes, the link lamp toggles every `BLINK_TICKS` ticks while the traffic stretch window is open, and it returns to steady ON when the window closes. Every lamp output comes from a register, so it follows its inputs one clock later.

Top module: `phy_led_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all three lamp outputs go to their OFF level after that edge. The OFF level is 0 with `led_invert`=0 and 1 with `led_invert`=1. The reset also clears the stretch, blink and prescaler state.
- R2: In every mode, `led_speed` is ON exactly when `link_up` and `spd_100` are both high. It is OFF when the link runs at 10 Mb/s. The output changes one clock after the inputs.
- R3: In traffic mode (`mode_sel` 2'b00 or 2'b01), `led_link` is steadily ON while `link_up` is high, whatever the transmit and receive activity.
- R4: In traffic mode, a single clock cycle with `tx_busy` or `rx_busy` high lights `led_act` for `STRETCH_TICKS` ticks, where a tick is one pulse every `TICK_DIV` clocks. Another event during the pulse starts the full length again. `col_det` has no effect on `led_act` in this mode.
- R5: In collision mode (2'b10) and duplex mode (2'b11), while `link_up` is high and the traffic stretch window is open, `led_link` starts dark and then toggles every `BLINK_TICKS` ticks. Once the window closes, `led_link` is steady ON.
- R6: In collision mode, `led_act` shows `col_det` events stretched as in R4. Transmit and receive activity has no effect on `led_act` in this mode.
- R7: In duplex mode, `led_act` follows `full_dup` one clock later. Collision and traffic inputs have no effect on `led_act` in this mode.
- R8: While `link_up` is low, `led_link` and `led_speed` are OFF in every mode, and `led_link` does not blink whatever the activity.
- R9: With `led_invert`=1, all three outputs are the logical inverse of their `led_invert`=0 values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_sel | input | 2 | Lamp mode: 00/01 traffic, 10 collision, 11 duplex (static) |
| led_invert | input | 1 | 1 = lamps lit by a low output level (static) |
| link_up | input | 1 | Link is good |
| spd_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| tx_busy | input | 1 | Transmitter active |
| rx_busy | input | 1 | Receiver active |
| col_det | input | 1 | Collision detected |
| full_dup | input | 1 | Link is full duplex |
| led_link | output | 1 | Link lamp |
| led_speed | output | 1 | Speed lamp |
| led_act | output | 1 | Activity / collision / duplex lamp |

## Verification
The bench builds the block with `TICK_DIV`=4, `STRETCH_TICKS`=6 and `BLINK_TICKS`=2. With these values a stretched pulse lasts 21 to 24 clocks and a blink half-period lasts 8 clocks. That is short enough to watch several complete blink cycles, the expiry of a single pulse, and a retrigger that crosses the end of the first pulse. The checks are placed with margins taken from the worst-case tick phase, so they do not depend on where the prescaler happens to be when an event arrives.

// File: rtl/phy_led_pkg.sv
// Shared types for the PHY status lamp controller.
package phy_led_pkg;

    // Decoded lamp mode.
    typedef enum logic [1:0] {
        LM_TRAFFIC = 2'd0,
        LM_COLL    = 2'd1,
        LM_DUPLEX  = 2'd2
    } led_mode_e;

    // Lamp vector positions inside the output register.
    localparam int LAMP_LINK  = 0;
    localparam int LAMP_SPEED = 1;
    localparam int LAMP_ACT   = 2;
    localparam int LAMP_COUNT = 3;

    // Turns the two-bit select into a mode; both 00 and 01 mean traffic.
    function automatic led_mode_e decode_mode(input logic [1:0] sel);
        case (sel)
            2'b10:   return LM_COLL;
            2'b11:   return LM_DUPLEX;
            default: return LM_TRAFFIC;
        endcase
    endfunction

endpackage

// File: rtl/led_tick_gen.sv
// Prescaler: emits a one-clock tick once every TICK_DIV system clocks.
// Assumes TICK_DIV >= 2. The tick is decoded from the counter state.
module led_tick_gen #(
    parameter int TICK_DIV = 50000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt;

    // Free-running modulo-TICK_DIV counter.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);

    // R4: the counter never leaves its modulo range.
    a_r4_tick_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
endmodule

// File: rtl/led_pulse_stretch.sv
// Pulse stretcher: any clock with evt high (re)loads a window of
// STRETCH_TICKS ticks. busy stays high while the window is open.
// Assumes tick is a one-clock pulse from the shared prescaler.
module led_pulse_stretch #(
    parameter int STRETCH_TICKS = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic evt,
    output logic busy
);
    localparam int SW = $clog2(STRETCH_TICKS + 1);
    localparam logic [SW-1:0] LOAD = SW'(STRETCH_TICKS);

    logic [SW-1:0] remain;

    // Reload on an event, otherwise count the window down on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)                       remain <= '0;
        else if (evt)                     remain <= LOAD;
        else if (tick && remain != '0)    remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);

    // R4: an event always leaves the window open on the next clock.
    a_r4_event_opens: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> busy);
    // R4: with no event and no tick, an open window stays open.
    a_r4_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !evt && !tick) |=> busy);
endmodule

// File: rtl/led_blink.sv
// Blink phase generator: while en is high, dark starts at 1 and toggles
// every BLINK_TICKS ticks. While en is low, it waits with dark preset.
// Assumes BLINK_TICKS >= 1.
module led_blink #(
    parameter int BLINK_TICKS = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic en,
    output logic dark
);
    localparam int BW = (BLINK_TICKS > 1) ? $clog2(BLINK_TICKS) : 1;
    localparam logic [BW-1:0] LAST = BW'(BLINK_TICKS - 1);

    logic [BW-1:0] cnt;

    // Count ticks while enabled and flip the phase after each half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt  <= '0;
            dark <= 1'b1;
        end else if (tick) begin
            if (cnt == LAST) begin
                cnt  <= '0;
                dark <= ~dark;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R5: the phase only moves on a tick.
    a_r5_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick) |=> $stable(dark));
    // R5: the half-period counter stays inside its range.
    a_r5_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
endmodule

// File: rtl/phy_led_ctrl.sv
// PHY status lamp controller top. It decodes the lamp mode, stretches
// traffic and collision events, blinks the link lamp in modes 2 and 3,
// and registers the three lamps before the polarity inversion.
// Assumes mode_sel and led_invert are static while out of reset.
module phy_led_ctrl
    import phy_led_pkg::*;
#(
    parameter int TICK_DIV      = 50000,
    parameter int STRETCH_TICKS = 50,
    parameter int BLINK_TICKS   = 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_sel,
    input  logic       led_invert,
    input  logic       link_up,
    input  logic       spd_100,
    input  logic       tx_busy,
    input  logic       rx_busy,
    input  logic       col_det,
    input  logic       full_dup,
    output logic       led_link,
    output logic       led_speed,
    output logic       led_act
);
    localparam int N_EVT   = 2;
    localparam int EV_TRAF = 0;
    localparam int EV_COLL = 1;

    led_mode_e               mode;
    logic                    tick;
    logic [N_EVT-1:0]        evt;
    logic [N_EVT-1:0]        busy;
    logic                    blink_mode;
    logic                    blink_en;
    logic                    dark;
    logic [LAMP_COUNT-1:0]   lamp_d;
    logic [LAMP_COUNT-1:0]   lamp_q;

    assign mode            = decode_mode(mode_sel);
    assign evt[EV_TRAF]    = tx_busy | rx_busy;
    assign evt[EV_COLL]    = col_det;
    assign blink_mode      = (mode != LM_TRAFFIC);
    assign blink_en        = blink_mode & link_up & busy[EV_TRAF];

    led_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    // One stretcher for each event source.
    for (genvar g = 0; g < N_EVT; g++) begin : g_stretch
        led_pulse_stretch #(.STRETCH_TICKS(STRETCH_TICKS)) u_str (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .evt   (evt[g]),
            .busy  (busy[g])
        );
    end

    led_blink #(.BLINK_TICKS(BLINK_TICKS)) u_blink (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .en    (blink_en),
        .dark  (dark)
    );

    // Lamp meanings for the selected mode, before registering.
    always_comb begin
        lamp_d             = '0;
        lamp_d[LAMP_LINK]  = link_up & ~(blink_en & dark);
        lamp_d[LAMP_SPEED] = link_up & spd_100;
        case (mode)
            LM_COLL:   lamp_d[LAMP_ACT] = busy[EV_COLL];
            LM_DUPLEX: lamp_d[LAMP_ACT] = full_dup;
            default:   lamp_d[LAMP_ACT] = busy[EV_TRAF];
        endcase
    end

    // Lamp register; reset holds every lamp OFF.
    always_ff @(posedge clk) begin
        if (!rst_n) lamp_q <= '0;
        else        lamp_q <= lamp_d;
    end

    assign led_link  = lamp_q[LAMP_LINK]  ^ led_invert;
    assign led_speed = lamp_q[LAMP_SPEED] ^ led_invert;
    assign led_act   = lamp_q[LAMP_ACT]   ^ led_invert;

    // R1: reset leaves every lamp OFF.
    a_r1_reset_off: assert property (@(posedge clk)
        !rst_n |=> (lamp_q == '0));
    // R2: the speed lamp is lit for a good 100 Mb/s link.
    a_r2_speed_on: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up && spd_100) |=> lamp_q[LAMP_SPEED]);
    // R3: in traffic mode a good link gives a steady link lamp.
    a_r3_traffic_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel[1] == 1'b0 && link_up) |=> lamp_q[LAMP_LINK]);
    // R7: in duplex mode the activity lamp tracks full_dup.
    a_r7_duplex_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b11) |=> (lamp_q[LAMP_ACT] == $past(full_dup)));
    // R8: a lost link darkens the link and speed lamps.
    a_r8_link_down_dark: assert property (@(posedge clk) disable iff (!rst_n)
        !link_up |=> (!lamp_q[LAMP_LINK] && !lamp_q[LAMP_SPEED]));
endmodule

// File: tb/tb_phy_led_ctrl.sv
// Directed bench for phy_led_ctrl: one task per scenario.
module tb_phy_led_ctrl;
    localparam int TD = 4;
    localparam int ST = 6;
    localparam int BT = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic led_invert = 1'b0;
    logic link_up = 1'b0, spd_100 = 1'b0, tx_busy = 1'b0, rx_busy = 1'b0;
    logic col_det = 1'b0, full_dup = 1'b0;
    logic led_link, led_speed, led_act;
    int total = 0, failed = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    phy_led_ctrl #(.TICK_DIV(TD), .STRETCH_TICKS(ST), .BLINK_TICKS(BT)) dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .led_invert(led_invert),
        .link_up(link_up), .spd_100(spd_100), .tx_busy(tx_busy), .rx_busy(rx_busy),
        .col_det(col_det), .full_dup(full_dup),
        .led_link(led_link), .led_speed(led_speed), .led_act(led_act)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Clears all inputs, sets the mode and polarity, and pulses reset.
    task automatic restart(input logic [1:0] m, input logic inv);
        @(negedge clk);
        {link_up, spd_100, tx_busy, rx_busy, col_det, full_dup} = '0;
        mode_sel = m; led_invert = inv; rst_n = 1'b0;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(2);
    endtask

    // R1: with all inputs active, reset holds every lamp at its OFF level.
    task automatic t_reset();
        for (int inv = 0; inv < 2; inv++) begin
            @(negedge clk);
            mode_sel = 2'b11; led_invert = inv[0]; rst_n = 1'b0;
            {link_up, spd_100, tx_busy, rx_busy, col_det, full_dup} = '1;
            wait_n(3);
            chk("R1 link", led_link, inv[0]);
            chk("R1 speed", led_speed, inv[0]);
            chk("R1 act", led_act, inv[0]);
        end
        rst_n = 1'b1;
    endtask

    // R2 / R3: speed lamp and steady link lamp in traffic mode.
    task automatic t_traffic_link();
        restart(2'b01, 1'b0);
        link_up = 1'b1; spd_100 = 1'b1;
        wait_n(2);
        chk("R2 speed 100", led_speed, 1'b1);
        spd_100 = 1'b0;
        wait_n(2);
        chk("R2 speed 10", led_speed, 1'b0);
        rx_busy = 1'b1;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (i % 5 == 0) chk("R3 link steady", led_link, 1'b1);
        end
        rx_busy = 1'b0;
    endtask

    // R4: single pulse length and retrigger; collision ignored in traffic mode.
    task automatic t_stretch();
        restart(2'b00, 1'b0);
        link_up = 1'b1;
        tx_busy = 1'b1; @(negedge clk); tx_busy = 1'b0;
        wait_n(3);  chk("R4 pulse start", led_act, 1'b1);
        wait_n(15); chk("R4 pulse held", led_act, 1'b1);
        wait_n(13); chk("R4 pulse end", led_act, 1'b0);
        rx_busy = 1'b1; @(negedge clk); rx_busy = 1'b0;
        wait_n(14);
        rx_busy = 1'b1; @(negedge clk); rx_busy = 1'b0;
        wait_n(16); chk("R4 retrigger held", led_act, 1'b1);
        wait_n(23); chk("R4 retrigger end", led_act, 1'b0);
        col_det = 1'b1; wait_n(6);
        chk("R4 collision ignored", led_act, 1'b0);
        col_det = 1'b0;
    endtask

    // R5: blinking link lamp in collision mode, then steady ON.
    task automatic t_blink();
        int toggles = 0;
        logic prev;
        restart(2'b10, 1'b0);
        link_up = 1'b1;
        wait_n(2);
        chk("R5 idle on", led_link, 1'b1);
        rx_busy = 1'b1;
        wait_n(2);
        chk("R5 starts dark", led_link, 1'b0);
        prev = led_link;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (led_link !== prev) toggles++;
            prev = led_link;
        end
        total++;
        if (toggles < 3) begin
            failed++;
            $display("FAIL R5 blink toggles actual=%0d expected>=3", toggles);
        end
        rx_busy = 1'b0;
        wait_n(40);
        chk("R5 steady after window", led_link, 1'b1);
        chk("R6 traffic ignored", led_act, 1'b0);
    endtask

    // R6: collision stretched on the activity lamp in collision mode.
    task automatic t_collision();
        restart(2'b10, 1'b0);
        link_up = 1'b1;
        col_det = 1'b1; @(negedge clk); col_det = 1'b0;
        wait_n(3);  chk("R6 collision on", led_act, 1'b1);
        wait_n(28); chk("R6 collision end", led_act, 1'b0);
    endtask

    // R7: duplex mode shows full_dup; collisions and traffic ignored.
    task automatic t_duplex();
        restart(2'b11, 1'b0);
        link_up = 1'b1; full_dup = 1'b1;
        wait_n(2);
        chk("R7 full duplex", led_act, 1'b1);
        full_dup = 1'b0; col_det = 1'b1; tx_busy = 1'b1;
        wait_n(3);
        chk("R7 half duplex", led_act, 1'b0);
        col_det = 1'b0; tx_busy = 1'b0;
    endtask

    // R8: link down means no link lamp, no blink, no speed lamp.
    task automatic t_link_down();
        int lit = 0;
        restart(2'b10, 1'b0);
        spd_100 = 1'b1; rx_busy = 1'b1;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (led_link !== 1'b0 || led_speed !== 1'b0) lit++;
        end
        total++;
        if (lit != 0) begin
            failed++;
            $display("FAIL R8 lamps lit cycles actual=%0d expected=0", lit);
        end
        rx_busy = 1'b0;
    endtask

    // R9: inverted polarity flips every lamp.
    task automatic t_invert();
        restart(2'b00, 1'b1);
        link_up = 1'b1;
        wait_n(2);
        chk("R9 link inverted", led_link, 1'b0);
        chk("R9 speed inverted", led_speed, 1'b1);
        chk("R9 act inverted", led_act, 1'b1);
        tx_busy = 1'b1; @(negedge clk); tx_busy = 1'b0;
        wait_n(3);
        chk("R9 act pulse inverted", led_act, 1'b0);
    endtask

    initial begin
        t_reset();
        t_traffic_link();
        t_stretch();
        t_blink();
        t_collision();
        t_duplex();
        t_link_down();
        t_invert();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++; failed++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end
endmodule